// File: doc/BRIEF.md
# Microcontroller Watchdog Timer Unit

This block is the watchdog of a small 8-bit microcontroller. It counts one of two clock-enable ticks, chosen by a configuration input. The first is a free-running tick from a low-power oscillator. The second is the instruction-rate tick, which is the system clock divided by four. The selected tick passes through a fixed divide-by-256 stage and then through a prescaler whose ratio is a power of two, set by a 3-bit select field in a software register. When the count runs out, the block raises a one-cycle reset pulse. In normal operation that pulse is a full chip reset, and the block also sets a time-out status flag. During power-down it is a warm reset instead, which the surrounding logic uses to restart only the program counter and stack pointer.

Software keeps the timer from expiring by issuing clear instructions. A configuration input picks the clear mode. In single mode, one clear instruction restarts the count. In pair mode, two distinct clear instructions must both be seen, in either order, before the count restarts. The external reset and the HALT instruction also restart the count. When the watchdog is disabled by configuration, it never expires and clear instructions are ignored. Everything runs in the system clock domain, and the ticks act as clock enables.

Top module: `mcu_watchdog`

## Requirements
- R1: With `cfgUseInstrClk` = 0 only `lpTick` advances the count; with `cfgUseInstrClk` = 1 only `instrTick` advances it, and the other tick has no effect.
- R2: After a restart, the time-out pulse appears on the clock edge that takes the 256·2^S-th selected tick, where S is register bits 2..0 (000 gives 1:1 and 111 gives 1:128). After the pulse the count starts again from zero.
- R3: The 8-bit register is written through `regWrEn`/`regWrData` and always shows on `regRdData`. Bits 7..3 are free flag bits that read back as written, and the value after reset is 8'h07.
- R4: A time-out with `powerDown` = 0 gives a one-cycle `chipResetPulse` and sets `timeoutFlag`.
- R5: A time-out with `powerDown` = 1 gives a one-cycle `warmResetPulse` and leaves `timeoutFlag` unchanged. The two pulses are never high together.
- R6: Driving `rstN` low, or `haltReq`, restarts the count (the divide-by-256 stage and the prescaler together). `haltReq` acts in either clear mode.
- R7: In single mode (`cfgPairClear` = 0), `clrSingle` restarts the count, and `clrFirst`/`clrSecond` are ignored.
- R8: In pair mode (`cfgPairClear` = 1), the count restarts on the edge where both `clrFirst` and `clrSecond` have been seen since the last pair clear, in either order or in the same cycle. Repeating one of them adds nothing, and `clrSingle` is ignored.
- R9: With `cfgEnable` = 0 no time-out occurs, the count does not advance, and clear instructions (including a half of a pair) are ignored.
- R10: When the instruction tick is the source, the count holds during `powerDown` and resumes afterwards. The low-power source keeps counting during `powerDown`.
- R11: `timeoutFlag` is cleared by `toClear` or by `rstN` low. If a time-out and `toClear` fall in the same cycle, the flag ends up set.
- R12: A clear (an instruction or `haltReq`) that falls in the same cycle as the terminal tick wins: no reset pulse is produced, and the full period starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | External reset, active low, asynchronous |
| cfgEnable | input | 1 | Watchdog enable option |
| cfgUseInstrClk | input | 1 | Source option: 1 selects the instruction tick, 0 the low-power tick |
| cfgPairClear | input | 1 | Clear-mode option: 1 selects pair mode |
| lpTick | input | 1 | Low-power oscillator tick (clock enable) |
| instrTick | input | 1 | Instruction-rate tick (clock enable) |
| powerDown | input | 1 | Device is in power-down |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register contents |
| clrSingle | input | 1 | Single clear instruction executed |
| clrFirst | input | 1 | First instruction of the clear pair executed |
| clrSecond | input | 1 | Second instruction of the clear pair executed |
| haltReq | input | 1 | HALT instruction executed |
| toClear | input | 1 | CPU request to clear the time-out flag |
| chipResetPulse | output | 1 | One-cycle full chip reset request |
| warmResetPulse | output | 1 | One-cycle warm reset request |
| timeoutFlag | output | 1 | Time-out status flag |

## Verification
The terminal tick of the count can land in the same cycle as a clear, and the flag-set from a time-out can land in the same cycle as a CPU flag clear. The bench steps a 1:1 setting to exactly 255 ticks and drives `clrSingle`, `haltReq` or `toClear` for the 256th edge. It then judges the outcome at the ports. A clear must suppress the pulse and restart a full 256-tick period. A flag clear must lose to the new time-out, leaving the flag set alongside the chip reset pulse.

// File: rtl/mcu_wdt_pkg.sv
package mcu_wdt_pkg;

  // Strobes from the control section to the counting datapath
  typedef struct packed {
    logic clearCount;  // restart the divide chain
    logic advance;     // take one selected tick
  } wdt_strobe_t;

  // Kind of reset generated by a time-out
  typedef enum logic [1:0] {
    FIRE_NONE = 2'd0,
    FIRE_CHIP = 2'd1,
    FIRE_WARM = 2'd2
  } wdt_fire_e;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import mcu_wdt_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 8,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned REG_W     = 8,
  parameter logic [REG_W-1:0] REG_RESET = 8'h07
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdt_strobe_t      strobe,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             atLimit
);

  localparam int unsigned MAX_SHIFT = (1 << SEL_W) - 1;
  localparam int unsigned PRE_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;
  localparam int unsigned FLAG_W    = REG_W - SEL_W;

  logic [SEL_W-1:0]     sel;
  logic [BASE_LOG2-1:0] baseCnt;
  logic [PRE_W-1:0]     preCnt;
  logic                 baseCarry;
  logic                 preLast;
  logic [PRE_W-1:0]     preMask;

  // Software register: select field in the low bits, free flags above
  logic [SEL_W-1:0]  selField;
  logic [FLAG_W-1:0] flagField;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selField  <= REG_RESET[SEL_W-1:0];
      flagField <= REG_RESET[REG_W-1:SEL_W];
    end else if (regWrEn) begin
      selField  <= regWrData[SEL_W-1:0];
      flagField <= regWrData[REG_W-1:SEL_W];
    end
  end

  assign regRdData = {flagField, selField};
  assign sel       = selField;

  // Fixed divide stage
  assign baseCarry = &baseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCnt <= '0;
    end else if (strobe.clearCount) begin
      baseCnt <= '0;
    end else if (strobe.advance) begin
      baseCnt <= baseCnt + 1'b1;
    end
  end

  // Prescaler terminal mask: low 'sel' bits set
  always_comb begin
    preMask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      preMask[i] = (i < int'(sel));
    end
  end

  // Terminal when all masked bits are ones (covers a select lowered mid-count)
  assign preLast = ((preCnt & preMask) == preMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (strobe.clearCount) begin
      preCnt <= '0;
    end else if (strobe.advance && baseCarry) begin
      if (preLast) begin
        preCnt <= '0;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign atLimit = baseCarry && preLast;

endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import mcu_wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgEnable,
  input  logic        cfgUseInstrClk,
  input  logic        cfgPairClear,
  input  logic        lpTick,
  input  logic        instrTick,
  input  logic        powerDown,
  input  logic        clrSingle,
  input  logic        clrFirst,
  input  logic        clrSecond,
  input  logic        haltReq,
  input  logic        toClear,
  input  logic        atLimit,
  output wdt_strobe_t strobe,
  output logic        chipResetPulse,
  output logic        warmResetPulse,
  output logic        timeoutFlag
);

  logic      selTick;
  logic      seenFirst;
  logic      seenSecond;
  logic      pairDone;
  logic      instrClear;
  logic      fireNow;
  wdt_fire_e fireKind;

  // The instruction tick stops with the system clock in power-down
  assign selTick = cfgUseInstrClk ? (instrTick && !powerDown) : lpTick;

  assign pairDone = (seenFirst || clrFirst) && (seenSecond || clrSecond);

  assign instrClear = cfgEnable && (cfgPairClear ? pairDone : clrSingle);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenFirst  <= 1'b0;
      seenSecond <= 1'b0;
    end else if (cfgEnable && cfgPairClear) begin
      if (pairDone) begin
        seenFirst  <= 1'b0;
        seenSecond <= 1'b0;
      end else begin
        seenFirst  <= seenFirst || clrFirst;
        seenSecond <= seenSecond || clrSecond;
      end
    end
  end

  always_comb begin
    strobe.clearCount = instrClear || haltReq;
    strobe.advance    = cfgEnable && selTick && !strobe.clearCount;
  end

  assign fireNow = strobe.advance && atLimit;

  always_comb begin
    if (!fireNow) begin
      fireKind = FIRE_NONE;
    end else if (powerDown) begin
      fireKind = FIRE_WARM;
    end else begin
      fireKind = FIRE_CHIP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chipResetPulse <= 1'b0;
      warmResetPulse <= 1'b0;
    end else begin
      chipResetPulse <= (fireKind == FIRE_CHIP);
      warmResetPulse <= (fireKind == FIRE_WARM);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutFlag <= 1'b0;
    end else if (fireKind == FIRE_CHIP) begin
      timeoutFlag <= 1'b1;
    end else if (toClear) begin
      timeoutFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/mcu_watchdog.sv
module mcu_watchdog
  import mcu_wdt_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 8,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned REG_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic             cfgUseInstrClk,
  input  logic             cfgPairClear,
  input  logic             lpTick,
  input  logic             instrTick,
  input  logic             powerDown,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             clrSingle,
  input  logic             clrFirst,
  input  logic             clrSecond,
  input  logic             haltReq,
  input  logic             toClear,
  output logic             chipResetPulse,
  output logic             warmResetPulse,
  output logic             timeoutFlag
);

  wdt_strobe_t strobe;
  logic        atLimit;

  wdt_control ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .cfgEnable      (cfgEnable),
    .cfgUseInstrClk (cfgUseInstrClk),
    .cfgPairClear   (cfgPairClear),
    .lpTick         (lpTick),
    .instrTick      (instrTick),
    .powerDown      (powerDown),
    .clrSingle      (clrSingle),
    .clrFirst       (clrFirst),
    .clrSecond      (clrSecond),
    .haltReq        (haltReq),
    .toClear        (toClear),
    .atLimit        (atLimit),
    .strobe         (strobe),
    .chipResetPulse (chipResetPulse),
    .warmResetPulse (warmResetPulse),
    .timeoutFlag    (timeoutFlag)
  );

  wdt_datapath #(
    .BASE_LOG2 (BASE_LOG2),
    .SEL_W     (SEL_W),
    .REG_W     (REG_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .atLimit   (atLimit)
  );

endmodule

// File: rtl/mcu_watchdog_chk.sv
module mcu_watchdog_chk #(
  parameter int unsigned REG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgEnable,
  input logic             cfgPairClear,
  input logic             powerDown,
  input logic             regWrEn,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] regRdData,
  input logic             clrSingle,
  input logic             haltReq,
  input logic             toClear,
  input logic             chipResetPulse,
  input logic             warmResetPulse,
  input logic             timeoutFlag
);

  // R4
  chip_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    chipResetPulse |=> !chipResetPulse);

  // R5
  warm_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    warmResetPulse |=> !warmResetPulse);

  // R5
  kinds_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(chipResetPulse && warmResetPulse));

  // R5
  warm_needs_pd_chk: assert property (@(posedge clk) disable iff (!rstN)
    warmResetPulse |-> $past(powerDown));

  // R4
  chip_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    chipResetPulse |-> timeoutFlag);

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> !(chipResetPulse || warmResetPulse));

  // R12
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq || (cfgEnable && !cfgPairClear && clrSingle))
      |=> !(chipResetPulse || warmResetPulse));

  // R11
  flag_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timeoutFlag) |-> $past(toClear));

  // R3
  reg_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regRdData == $past(regWrData)));

endmodule

bind mcu_watchdog mcu_watchdog_chk #(.REG_W(REG_W)) chk_i (
  .clk            (clk),
  .rstN           (rstN),
  .cfgEnable      (cfgEnable),
  .cfgPairClear   (cfgPairClear),
  .powerDown      (powerDown),
  .regWrEn        (regWrEn),
  .regWrData      (regWrData),
  .regRdData      (regRdData),
  .clrSingle      (clrSingle),
  .haltReq        (haltReq),
  .toClear        (toClear),
  .chipResetPulse (chipResetPulse),
  .warmResetPulse (warmResetPulse),
  .timeoutFlag    (timeoutFlag)
);

// File: tb/mcu_watchdog_tb_top.sv
`timescale 1ns/1ps
module mcu_watchdog_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgEnable = 1'b1;
  logic       cfgUseInstrClk = 1'b0;
  logic       cfgPairClear = 1'b0;
  logic       lpTick = 1'b0;
  logic       instrTick = 1'b0;
  logic       powerDown = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       clrSingle = 1'b0;
  logic       clrFirst = 1'b0;
  logic       clrSecond = 1'b0;
  logic       haltReq = 1'b0;
  logic       toClear = 1'b0;
  logic       chipResetPulse;
  logic       warmResetPulse;
  logic       timeoutFlag;

  int checks = 0;
  int fails = 0;
  bit summaryDone = 0;

  always #2 clk = ~clk;

  mcu_watchdog dut_i (
    .clk            (clk),
    .rstN           (rstN),
    .cfgEnable      (cfgEnable),
    .cfgUseInstrClk (cfgUseInstrClk),
    .cfgPairClear   (cfgPairClear),
    .lpTick         (lpTick),
    .instrTick      (instrTick),
    .powerDown      (powerDown),
    .regWrEn        (regWrEn),
    .regWrData      (regWrData),
    .regRdData      (regRdData),
    .clrSingle      (clrSingle),
    .clrFirst       (clrFirst),
    .clrSecond      (clrSecond),
    .haltReq        (haltReq),
    .toClear        (toClear),
    .chipResetPulse (chipResetPulse),
    .warmResetPulse (warmResetPulse),
    .timeoutFlag    (timeoutFlag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Full reset with all stimulus idle
  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    {lpTick, instrTick, powerDown, regWrEn, clrSingle, clrFirst, clrSecond,
     haltReq, toClear} = '0;
    cfgEnable = 1'b1; cfgUseInstrClk = 1'b0; cfgPairClear = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeReg(input logic [7:0] v);
    regWrEn = 1'b1; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Restart the count with ticks held off, via HALT
  task automatic restart();
    lpTick = 1'b0; instrTick = 1'b0;
    haltReq = 1'b1;
    @(negedge clk);
    haltReq = 1'b0;
  endtask

  // Advance n edges; any pulse seen is a failure
  task automatic step(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (chipResetPulse || warmResetPulse) seen++;
    end
    check(seen == 0, req, "unexpected reset pulses", seen, 0);
  endtask

  // One-edge strobe of a clear-type input: 0 single,1 first,2 second,3 halt,4 toClear
  task automatic strobeIn(input int which);
    case (which)
      0: clrSingle = 1'b1;
      1: clrFirst  = 1'b1;
      2: clrSecond = 1'b1;
      3: haltReq   = 1'b1;
      default: toClear = 1'b1;
    endcase
    @(negedge clk);
    {clrSingle, clrFirst, clrSecond, haltReq, toClear} = '0;
  endtask

  // Count edges until a pulse appears
  task automatic measure(input int maxCyc, output int cyc, output bit gotChip,
                         output bit gotWarm);
    bit done = 0;
    cyc = 0; gotChip = 0; gotWarm = 0;
    while (!done && cyc < maxCyc) begin
      @(negedge clk);
      cyc++;
      if (chipResetPulse || warmResetPulse) begin
        gotChip = chipResetPulse; gotWarm = warmResetPulse; done = 1;
      end
    end
  endtask

  task automatic testReset();
    doReset();
    check(regRdData == 8'h07, "R3", "reset register", regRdData, 8'h07);
    check(!timeoutFlag && !chipResetPulse && !warmResetPulse, "R4", "reset outputs",
          {timeoutFlag, chipResetPulse, warmResetPulse}, 0);
  endtask

  task automatic testPeriods();
    int cyc; bit c; bit w;
    doReset();
    for (int ws = 0; ws < 8; ws++) begin
      writeReg({5'b10110, 3'(ws)});
      check(regRdData == {5'b10110, 3'(ws)}, "R3", "flags readback", regRdData,
            {5'b10110, 3'(ws)});
      restart();
      lpTick = 1'b1;
      measure(40000, cyc, c, w);
      check(cyc == (256 << ws) && c && !w, "R2", "period for select", cyc, 256 << ws);
      check(timeoutFlag, "R4", "flag after chip reset", timeoutFlag, 1);
      @(negedge clk);
      check(!chipResetPulse, "R4", "pulse width", chipResetPulse, 0);
      lpTick = 1'b0;
      strobeIn(4);
      check(!timeoutFlag, "R11", "toClear drops flag", timeoutFlag, 0);
    end
  endtask

  task automatic testSource();
    int cyc; bit c; bit w;
    doReset();
    writeReg(8'h00);
    cfgUseInstrClk = 1'b1;
    restart();
    lpTick = 1'b1;
    step(600, "R1");
    instrTick = 1'b1;
    restart(); instrTick = 1'b1; lpTick = 1'b1;
    measure(1000, cyc, c, w);
    check(cyc == 256 && c, "R1", "instruction tick source", cyc, 256);
    cfgUseInstrClk = 1'b0;
    restart();
    instrTick = 1'b1;
    step(600, "R1");
    lpTick = 1'b1;
    measure(1000, cyc, c, w);
    check(cyc == 256 && c, "R1", "low-power tick source", cyc, 256);
  endtask

  task automatic testPowerDown();
    int cyc; bit c; bit w;
    doReset();
    writeReg(8'h00);
    powerDown = 1'b1;
    restart();
    lpTick = 1'b1;
    measure(1000, cyc, c, w);
    check(cyc == 256 && w && !c, "R5", "warm reset in power-down", cyc, 256);
    check(!timeoutFlag, "R5", "flag untouched by warm", timeoutFlag, 0);
    lpTick = 1'b0;
    cfgUseInstrClk = 1'b1;
    restart();
    instrTick = 1'b1;
    step(600, "R10");
    powerDown = 1'b0;
    measure(1000, cyc, c, w);
    check(cyc == 256 && c, "R10", "instruction source held in power-down", cyc, 256);
  endtask

  task automatic testSingle();
    int cyc; bit c; bit w;
    doReset();
    writeReg(8'h00);
    restart();
    lpTick = 1'b1;
    step(100, "R7");
    strobeIn(0);
    measure(1000, cyc, c, w);
    check(cyc == 256, "R7", "single clear restarts", cyc, 256);
    restart();
    lpTick = 1'b1;
    step(100, "R7");
    clrFirst = 1'b1; clrSecond = 1'b1;
    @(negedge clk);
    clrFirst = 1'b0; clrSecond = 1'b0;
    measure(1000, cyc, c, w);
    check(cyc == 155, "R7", "pair inputs ignored in single mode", cyc, 155);
  endtask

  task automatic testPair();
    int cyc; bit c; bit w;
    doReset();
    writeReg(8'h00);
    cfgPairClear = 1'b1;
    restart();
    lpTick = 1'b1;
    step(100, "R8");
    strobeIn(1);
    step(49, "R8");
    strobeIn(1);
    step(19, "R8");
    strobeIn(0);
    step(29, "R8");
    strobeIn(2);
    measure(1000, cyc, c, w);
    check(cyc == 256, "R8", "pair completes on second", cyc, 256);
    restart();
    lpTick = 1'b1;
    step(100, "R8");
    strobeIn(2);
    step(99, "R8");
    strobeIn(0);
    measure(1000, cyc, c, w);
    check(cyc == 55, "R8", "half pair and single do not clear", cyc, 55);
    restart();
    lpTick = 1'b1;
    step(50, "R8");
    strobeIn(1);
    measure(1000, cyc, c, w);
    check(cyc == 256, "R8", "reverse order completes", cyc, 256);
    restart();
    lpTick = 1'b1;
    step(50, "R8");
    clrFirst = 1'b1; clrSecond = 1'b1;
    @(negedge clk);
    clrFirst = 1'b0; clrSecond = 1'b0;
    measure(1000, cyc, c, w);
    check(cyc == 256, "R8", "same-cycle pair completes", cyc, 256);
  endtask

  task automatic testDisabled();
    int cyc; bit c; bit w;
    doReset();
    writeReg(8'h00);
    cfgPairClear = 1'b1;
    restart();
    cfgEnable = 1'b0;
    lpTick = 1'b1;
    step(1000, "R9");
    strobeIn(1);
    step(10, "R9");
    cfgEnable = 1'b1;
    step(100, "R9");
    strobeIn(2);
    measure(1000, cyc, c, w);
    check(cyc == 155, "R9", "clear ignored while disabled", cyc, 155);
  endtask

  task automatic testRace();
    int cyc; bit c; bit w;
    doReset();
    writeReg(8'h00);
    restart();
    lpTick = 1'b1;
    step(255, "R12");
    clrSingle = 1'b1;
    @(negedge clk);
    clrSingle = 1'b0;
    check(!chipResetPulse, "R12", "clear beats terminal tick", chipResetPulse, 0);
    measure(1000, cyc, c, w);
    check(cyc == 256, "R12", "full period after race", cyc, 256);
    restart();
    lpTick = 1'b1;
    step(255, "R6");
    haltReq = 1'b1;
    @(negedge clk);
    haltReq = 1'b0;
    check(!chipResetPulse, "R6", "halt beats terminal tick", chipResetPulse, 0);
    restart();
    lpTick = 1'b1;
    step(255, "R11");
    toClear = 1'b1;
    @(negedge clk);
    toClear = 1'b0;
    check(chipResetPulse && timeoutFlag, "R11", "set wins over toClear",
          {chipResetPulse, timeoutFlag}, 3);
  endtask

  task automatic testExtReset();
    int cyc; bit c; bit w;
    doReset();
    restart();
    lpTick = 1'b1;
    step(200, "R6");
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check(regRdData == 8'h07, "R3", "register after reset", regRdData, 8'h07);
    measure(40000, cyc, c, w);
    check(cyc == 32768, "R6", "external reset restarts count", cyc, 32768);
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    finishRun();
  end

  initial begin
    testReset();
    testPeriods();
    testSource();
    testPowerDown();
    testSingle();
    testPair();
    testDisabled();
    testRace();
    testExtReset();
    finishRun();
  end

endmodule